// File: doc/BRIEF.md
# Store Buffer with Forwarding

A per-core write buffer placed between the store port of a processor and its coherent cache. A store that arrives while a slot is free is taken in the same cycle, so the core never waits on ownership traffic. Each buffered store waits until its line has write permission, which a grant input reports by address once every invalidate acknowledgement for that line has arrived. It then leaves through a single write port to the cache.

Entries may leave in an order that differs from the order they arrived in. A younger store whose line is already owned can go ahead of an older store that is still waiting. Two controls limit that freedom. A store barrier tags later stores with a new epoch, and only the oldest live epoch may drain. A full barrier holds the core until the buffer is empty. Loads from the same core look into the buffer byte by byte and take the youngest buffered value of each byte.

Top module: `store_buffer`

## Requirements
- R1: When fewer than DEPTH entries are buffered and no full-barrier stall is active, `st_ready_o` is 1 and a store with `st_valid_i` high is taken at that clock edge.
- R2: In each cycle `dr_valid_o` is 1 exactly when some entry may drain. The port then shows address, data and byte strobes of the oldest entry that may drain, and that entry is freed at the next edge. An entry may drain only if it is granted, belongs to the oldest live epoch, and has no older buffered entry with the same address.
- R3: A grant (`gnt_valid_i` with `gnt_addr_i`) marks every entry of that address that was already buffered before the edge, and the mark stays until the entry drains. A store taken in the same cycle as a grant to its address is not marked.
- R4: Without a barrier, a younger granted entry drains while an older entry of another address is still ungranted.
- R5: A store taken together with or after `sbar_i` drains only after every store taken before that barrier has drained.
- R6: With DEPTH entries buffered, `st_ready_o` is 0 and a presented store is not taken.
- R7: For `ld_addr_i`, bit b of `ld_hit_be_o` is 1 when some buffered entry at that address enables byte b, and byte b of `ld_data_o` (bits 8b+7..8b) is that byte from the youngest such entry, else 0. A store taken at an edge is visible to loads from the next cycle.
- R8: Stores to one address drain in the order they were taken, so the memory image after all drains equals the last write of each byte in program order.
- R9: `fence_stall_o` is 1 while `fence_req_i` is 1 and the buffer is not empty, and `st_ready_o` is 0 during that stall.
- R10: `empty_o` is 1 exactly when no entry is buffered.
- R11: After reset the buffer is empty, nothing drains and `st_ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid_i | input | 1 | Core presents a store |
| st_addr_i | input | ADDR_W | Store line address |
| st_data_i | input | DATA_W | Store data |
| st_be_i | input | DATA_W/8 | Store byte enables |
| st_ready_o | output | 1 | Store is taken this cycle |
| sbar_i | input | 1 | Store barrier, ordered before a store in the same cycle |
| fence_req_i | input | 1 | Full barrier request |
| fence_stall_o | output | 1 | Core must hold for the full barrier |
| gnt_valid_i | input | 1 | Write permission granted for a line |
| gnt_addr_i | input | ADDR_W | Line that received permission |
| ld_addr_i | input | ADDR_W | Load lookup address |
| ld_hit_be_o | output | DATA_W/8 | Bytes found in the buffer |
| ld_data_o | output | DATA_W | Forwarded bytes, zero where not found |
| dr_valid_o | output | 1 | Drain write to the cache |
| dr_addr_o | output | ADDR_W | Drain address |
| dr_data_o | output | DATA_W | Drain data |
| dr_be_o | output | DATA_W/8 | Drain byte strobes |
| empty_o | output | 1 | No entry buffered |

## Verification
Load results, ready, stall and empty status are functions of the state registered at the last edge, so they are due in the same cycle as the address or request that selects them. A store taken at an edge shows up in forwarding one cycle later. A grant latched at an edge lets the drain appear one cycle after that, and the entry disappears at the following edge. The bench samples every output at the falling edge. It first compares them with its model as it stood before that edge, and only then applies the drain, grant, barrier and store of the cycle to the model, so each result is checked in the cycle the counted registers make it due.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
    // default geometry of the write buffer
    localparam int unsigned SB_DEPTH  = 8;
    localparam int unsigned SB_ADDR_W = 16;
    localparam int unsigned SB_DATA_W = 32;
endpackage

// File: rtl/sb_slot_pick.sv
// Picks the lowest-indexed free slot as a one-hot mask.
module sb_slot_pick #(
    parameter int unsigned N = 8
) (
    input  logic [N-1:0] free_i,
    output logic         found_o,
    output logic [N-1:0] slot_oh_o
);
    assign slot_oh_o = free_i & (~free_i + 1'b1);
    assign found_o   = |free_i;
endmodule

// File: rtl/sb_fwd.sv
// Per-byte forwarding: each byte comes from the youngest matching entry.
module sb_fwd #(
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 32
) (
    input  logic [DEPTH-1:0]                  vld_i,
    input  logic [DEPTH-1:0][ADDR_W-1:0]      addr_i,
    input  logic [DEPTH-1:0][DATA_W-1:0]      data_i,
    input  logic [DEPTH-1:0][DATA_W/8-1:0]    be_i,
    input  logic [DEPTH-1:0][DEPTH-1:0]       older_i,   // [i][j]: j is older than i
    input  logic [ADDR_W-1:0]                 ld_addr_i,
    output logic [DATA_W/8-1:0]               ld_be_o,
    output logic [DATA_W-1:0]                 ld_data_o
);
    localparam int unsigned BE_W = DATA_W / 8;

    for (genvar b = 0; b < BE_W; b++) begin : g_byte
        logic [7:0] byte_v;
        logic       hit_v;
        always_comb begin
            logic [DEPTH-1:0] cand;
            logic             keep;
            for (int i = 0; i < DEPTH; i++) begin
                cand[i] = vld_i[i] && (addr_i[i] == ld_addr_i) && be_i[i][b];
            end
            byte_v = '0;
            hit_v  = 1'b0;
            for (int i = 0; i < DEPTH; i++) begin
                keep = cand[i];
                // drop i if a younger candidate exists
                for (int j = 0; j < DEPTH; j++) begin
                    if (cand[j] && older_i[j][i]) keep = 1'b0;
                end
                if (keep) begin
                    byte_v = byte_v | data_i[i][b*8 +: 8];
                    hit_v  = 1'b1;
                end
            end
        end
        assign ld_data_o[b*8 +: 8] = byte_v;
        assign ld_be_o[b]          = hit_v;
    end
endmodule

// File: rtl/sb_drain_sel.sv
// Chooses the oldest entry allowed to drain this cycle.
module sb_drain_sel #(
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned EP_W   = 4
) (
    input  logic [DEPTH-1:0]             vld_i,
    input  logic [DEPTH-1:0]             gnt_i,
    input  logic [DEPTH-1:0][ADDR_W-1:0] addr_i,
    input  logic [DEPTH-1:0][EP_W-1:0]   ep_i,
    input  logic [DEPTH-1:0][DEPTH-1:0]  older_i,
    output logic [DEPTH-1:0]             sel_o,
    output logic                         any_o
);
    logic [DEPTH-1:0] head;
    logic [DEPTH-1:0] elig;
    logic [EP_W-1:0]  oldest_ep;

    for (genvar i = 0; i < DEPTH; i++) begin : g_head
        assign head[i] = vld_i[i] & ~|(older_i[i] & vld_i);
    end

    always_comb begin
        oldest_ep = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (head[i]) oldest_ep = oldest_ep | ep_i[i];
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_elig
        logic [DEPTH-1:0] same_addr;
        for (genvar j = 0; j < DEPTH; j++) begin : g_cmp
            assign same_addr[j] = (addr_i[i] == addr_i[j]);
        end
        logic blocked;
        assign blocked = |(older_i[i] & vld_i & same_addr);
        assign elig[i] = vld_i[i] & gnt_i[i] & (ep_i[i] == oldest_ep) & ~blocked;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_sel
        assign sel_o[i] = elig[i] & ~|(older_i[i] & elig);
    end

    assign any_o = |elig;
endmodule

// File: rtl/store_buffer.sv
module store_buffer
    import sbuf_pkg::*;
#(
    parameter int unsigned DEPTH  = SB_DEPTH,
    parameter int unsigned ADDR_W = SB_ADDR_W,
    parameter int unsigned DATA_W = SB_DATA_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                st_valid_i,
    input  logic [ADDR_W-1:0]   st_addr_i,
    input  logic [DATA_W-1:0]   st_data_i,
    input  logic [DATA_W/8-1:0] st_be_i,
    output logic                st_ready_o,
    input  logic                sbar_i,
    input  logic                fence_req_i,
    output logic                fence_stall_o,
    input  logic                gnt_valid_i,
    input  logic [ADDR_W-1:0]   gnt_addr_i,
    input  logic [ADDR_W-1:0]   ld_addr_i,
    output logic [DATA_W/8-1:0] ld_hit_be_o,
    output logic [DATA_W-1:0]   ld_data_o,
    output logic                dr_valid_o,
    output logic [ADDR_W-1:0]   dr_addr_o,
    output logic [DATA_W-1:0]   dr_data_o,
    output logic [DATA_W/8-1:0] dr_be_o,
    output logic                empty_o
);
    localparam int unsigned BE_W = DATA_W / 8;
    // live epochs never exceed DEPTH, so twice that range cannot alias
    localparam int unsigned EP_W = $clog2(DEPTH) + 1;

    typedef struct packed {
        logic [DEPTH-1:0]             vld;
        logic [DEPTH-1:0]             gnt;
        logic [DEPTH-1:0][ADDR_W-1:0] addr;
        logic [DEPTH-1:0][DATA_W-1:0] data;
        logic [DEPTH-1:0][BE_W-1:0]   be;
        logic [DEPTH-1:0][EP_W-1:0]   ep;
        logic [DEPTH-1:0][DEPTH-1:0]  older;
        logic [EP_W-1:0]              cur_ep;
        logic                         open_ep;  // a store carries cur_ep
    } sb_state_t;

    sb_state_t q, d;

    logic             slot_found;
    logic [DEPTH-1:0] slot_oh;
    logic [DEPTH-1:0] dr_sel;
    logic             dr_any;
    logic             accept;
    logic             bar_fire;
    logic [EP_W-1:0]  ep_n;

    sb_slot_pick #(.N(DEPTH)) u_pick (
        .free_i    (~q.vld),
        .found_o   (slot_found),
        .slot_oh_o (slot_oh)
    );

    sb_drain_sel #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .EP_W(EP_W)) u_drain (
        .vld_i   (q.vld),
        .gnt_i   (q.gnt),
        .addr_i  (q.addr),
        .ep_i    (q.ep),
        .older_i (q.older),
        .sel_o   (dr_sel),
        .any_o   (dr_any)
    );

    sb_fwd #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fwd (
        .vld_i     (q.vld),
        .addr_i    (q.addr),
        .data_i    (q.data),
        .be_i      (q.be),
        .older_i   (q.older),
        .ld_addr_i (ld_addr_i),
        .ld_be_o   (ld_hit_be_o),
        .ld_data_o (ld_data_o)
    );

    assign empty_o       = ~|q.vld;
    assign fence_stall_o = fence_req_i & ~empty_o;
    assign st_ready_o    = slot_found & ~fence_stall_o;
    assign accept        = st_valid_i & st_ready_o;
    assign dr_valid_o    = dr_any;

    always_comb begin
        dr_addr_o = '0;
        dr_data_o = '0;
        dr_be_o   = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (dr_sel[i]) begin
                dr_addr_o = dr_addr_o | q.addr[i];
                dr_data_o = dr_data_o | q.data[i];
                dr_be_o   = dr_be_o   | q.be[i];
            end
        end
    end

    always_comb begin
        d        = q;
        bar_fire = sbar_i & q.open_ep;
        ep_n     = bar_fire ? q.cur_ep + 1'b1 : q.cur_ep;
        d.cur_ep = ep_n;
        if (bar_fire) d.open_ep = 1'b0;

        for (int i = 0; i < DEPTH; i++) begin
            if (dr_sel[i]) d.vld[i] = 1'b0;
            if (gnt_valid_i && q.vld[i] && (q.addr[i] == gnt_addr_i)) d.gnt[i] = 1'b1;
        end

        if (accept) begin
            d.open_ep = 1'b1;
            for (int i = 0; i < DEPTH; i++) begin
                if (slot_oh[i]) begin
                    d.vld[i]   = 1'b1;
                    d.gnt[i]   = 1'b0;
                    d.addr[i]  = st_addr_i;
                    d.data[i]  = st_data_i;
                    d.be[i]    = st_be_i;
                    d.ep[i]    = ep_n;
                    d.older[i] = q.vld & ~dr_sel;
                end else begin
                    d.older[i] = q.older[i] & ~slot_oh;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R1: a taken store without a drain adds one entry
    a_r1_accept_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid_i && st_ready_o && !dr_valid_o)
        |=> ($countones(q.vld) == $past($countones(q.vld)) + 1));

    // R6: a refused store leaves the occupancy unchanged
    a_r6_refused_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid_i && !st_ready_o && !dr_valid_o)
        |=> ($countones(q.vld) == $past($countones(q.vld))));

    // R2: at most one entry leaves per cycle, and only a granted one
    a_r2_one_drain: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dr_sel));
    a_r2_drain_granted: assert property (@(posedge clk) disable iff (!rst_n)
        dr_valid_o |-> ((dr_sel & q.gnt) == dr_sel));

    // R10: an empty buffer neither drains nor forwards
    a_r10_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        empty_o |-> (!dr_valid_o && (ld_hit_be_o == '0)));

    // R3: a grant mark stays until the entry leaves
    for (genvar i = 0; i < DEPTH; i++) begin : g_chk
        a_r3_gnt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (q.vld[i] && q.gnt[i]) |=> (!q.vld[i] || q.gnt[i]));
    end
endmodule

// File: tb/tb_store_buffer.sv
`timescale 1ns/1ps
module tb_store_buffer;
    localparam int DEPTH = 4;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        st_valid = 0;
    logic [3:0]  st_addr = 0;
    logic [15:0] st_data = 0;
    logic [1:0]  st_be = 0;
    logic        st_ready;
    logic        sbar = 0;
    logic        fence_req = 0;
    logic        fence_stall;
    logic        gnt_valid = 0;
    logic [3:0]  gnt_addr = 0;
    logic [3:0]  ld_addr = 0;
    logic [1:0]  ld_hit_be;
    logic [15:0] ld_data;
    logic        dr_valid;
    logic [3:0]  dr_addr;
    logic [15:0] dr_data;
    logic [1:0]  dr_be;
    logic        empty;

    store_buffer #(.DEPTH(DEPTH), .ADDR_W(4), .DATA_W(16)) dut (
        .clk(clk), .rst_n(rst_n),
        .st_valid_i(st_valid), .st_addr_i(st_addr), .st_data_i(st_data), .st_be_i(st_be),
        .st_ready_o(st_ready), .sbar_i(sbar), .fence_req_i(fence_req),
        .fence_stall_o(fence_stall), .gnt_valid_i(gnt_valid), .gnt_addr_i(gnt_addr),
        .ld_addr_i(ld_addr), .ld_hit_be_o(ld_hit_be), .ld_data_o(ld_data),
        .dr_valid_o(dr_valid), .dr_addr_o(dr_addr), .dr_data_o(dr_data), .dr_be_o(dr_be),
        .empty_o(empty)
    );

    always #2 clk = ~clk;

    int vectors = 0;
    int miscompares = 0;
    int cycles = 0;

    // reference model
    bit          p_v[8];
    logic [3:0]  p_addr[8];
    logic [15:0] p_data[8];
    logic [1:0]  p_be[8];
    int          p_ep[8];
    bit          p_g[8];
    int          p_seq[8];
    int          b_ep = 0;
    int          gseq = 0;
    logic [15:0] mem[16];
    logic [15:0] img[16];
    bit          ld_hold = 0;
    logic [31:0] seed = 32'h1234_5678;

    bit          cap_dr_valid, cap_st_ready, cap_fs, cap_empty;
    logic [3:0]  cap_dr_addr;
    logic [15:0] cap_dr_data, cap_ld_data;
    logic [1:0]  cap_ld_be;

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            miscompares++;
            $display("FAIL R2 watchdog act=%0d exp=%0d", cycles, 100000);
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s act=%h exp=%h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] rnd();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed;
    endfunction

    task automatic observe();
        int cnt; int bseq; int mep; int best; bit ok; bit fs;
        logic [1:0] eb; logic [15:0] ed;
        cnt = 0;
        for (int k = 0; k < 8; k++) if (p_v[k]) cnt++;
        // R7 forwarding
        eb = 0; ed = 0;
        for (int b = 0; b < 2; b++) begin
            bseq = -1;
            for (int k = 0; k < 8; k++) begin
                if (p_v[k] && p_addr[k] == ld_addr && p_be[k][b] && p_seq[k] > bseq) begin
                    bseq = p_seq[k];
                    ed[b*8 +: 8] = p_data[k][b*8 +: 8];
                    eb[b] = 1'b1;
                end
            end
        end
        chk(ld_hit_be == eb, "R7 ld_hit_be", 32'(ld_hit_be), 32'(eb));
        chk(ld_data == ed, "R7 ld_data", 32'(ld_data), 32'(ed));
        // status
        fs = fence_req && cnt != 0;
        chk(empty == (cnt == 0), "R10 empty", 32'(empty), 32'(cnt == 0));
        chk(fence_stall == fs, "R9 fence_stall", 32'(fence_stall), 32'(fs));
        if (cnt >= DEPTH) chk(st_ready == 1'b0, "R6 st_ready", 32'(st_ready), 0);
        else              chk(st_ready == !fs, "R1 st_ready", 32'(st_ready), 32'(!fs));
        // drain
        mep = 32'h7fff_ffff;
        for (int k = 0; k < 8; k++) if (p_v[k] && p_ep[k] < mep) mep = p_ep[k];
        best = -1;
        for (int k = 0; k < 8; k++) begin
            if (p_v[k] && p_g[k] && p_ep[k] == mep) begin
                ok = 1;
                for (int j = 0; j < 8; j++)
                    if (p_v[j] && p_addr[j] == p_addr[k] && p_seq[j] < p_seq[k]) ok = 0;
                if (ok && (best < 0 || p_seq[k] < p_seq[best])) best = k;
            end
        end
        chk(dr_valid == (best >= 0), "R2 dr_valid", 32'(dr_valid), 32'(best >= 0));
        if (dr_valid && best >= 0) begin
            chk(dr_addr == p_addr[best], "R2 dr_addr", 32'(dr_addr), 32'(p_addr[best]));
            chk(dr_data == p_data[best], "R2 dr_data", 32'(dr_data), 32'(p_data[best]));
            chk(dr_be == p_be[best], "R2 dr_be", 32'(dr_be), 32'(p_be[best]));
            for (int b = 0; b < 2; b++)
                if (p_be[best][b]) mem[p_addr[best]][b*8 +: 8] = p_data[best][b*8 +: 8];
            p_v[best] = 0;
        end
        cap_dr_valid = dr_valid; cap_dr_addr = dr_addr; cap_dr_data = dr_data;
        cap_st_ready = st_ready; cap_fs = fence_stall; cap_empty = empty;
        cap_ld_data = ld_data; cap_ld_be = ld_hit_be;
        // inputs of this cycle, in the order the edge applies them
        if (gnt_valid)
            for (int k = 0; k < 8; k++) if (p_v[k] && p_addr[k] == gnt_addr) p_g[k] = 1;
        if (sbar) b_ep++;
        if (st_valid && st_ready) begin
            for (int k = 0; k < 8; k++) begin
                if (!p_v[k]) begin
                    p_v[k] = 1; p_addr[k] = st_addr; p_data[k] = st_data; p_be[k] = st_be;
                    p_ep[k] = b_ep; p_g[k] = 0; p_seq[k] = gseq++;
                    for (int b = 0; b < 2; b++)
                        if (st_be[b]) img[st_addr][b*8 +: 8] = st_data[b*8 +: 8];
                    break;
                end
            end
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        observe();
        @(posedge clk);
        #1;
        st_valid = 0; sbar = 0; gnt_valid = 0;
        if (!ld_hold) ld_addr = ld_addr + 1'b1;
    endtask

    task automatic put(input logic [3:0] a, input logic [15:0] dt, input logic [1:0] be);
        st_valid = 1; st_addr = a; st_data = dt; st_be = be;
    endtask

    task automatic grant(input logic [3:0] a);
        gnt_valid = 1; gnt_addr = a;
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin mem[i] = 0; img[i] = 0; end
        for (int k = 0; k < 8; k++) p_v[k] = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R11 reset state
        chk(empty == 1'b1, "R11 empty", 32'(empty), 1);
        chk(dr_valid == 1'b0, "R11 dr_valid", 32'(dr_valid), 0);
        chk(st_ready == 1'b1, "R11 st_ready", 32'(st_ready), 1);
        @(posedge clk); #1;

        // R4: younger granted store overtakes older ungranted one
        put(4'h1, 16'hA1A1, 2'b11); cyc();
        put(4'h2, 16'hB2B2, 2'b11); cyc();
        grant(4'h2); cyc();
        cyc();
        chk(cap_dr_valid && cap_dr_addr == 4'h2, "R4 overtake", 32'(cap_dr_addr), 2);
        grant(4'h1); cyc(); cyc();
        chk(cap_dr_valid && cap_dr_addr == 4'h1, "R4 older later", 32'(cap_dr_addr), 1);

        // R5: barrier between stores to 4 and 5
        put(4'h4, 16'h0404, 2'b11); cyc();
        sbar = 1; put(4'h5, 16'h0505, 2'b11); cyc();
        grant(4'h5); cyc(); cyc();
        chk(!cap_dr_valid, "R5 held behind barrier", 32'(cap_dr_valid), 0);
        grant(4'h4); cyc(); cyc();
        chk(cap_dr_valid && cap_dr_addr == 4'h4, "R5 older epoch first", 32'(cap_dr_addr), 4);
        cyc();
        chk(cap_dr_valid && cap_dr_addr == 4'h5, "R5 next epoch", 32'(cap_dr_addr), 5);
        chk(cap_dr_valid, "R3 grant kept", 32'(cap_dr_valid), 1);

        // R3: grant in the same cycle as the store does not mark it
        put(4'h7, 16'h0707, 2'b11); grant(4'h7); cyc();
        cyc(); cyc();
        chk(!cap_dr_valid, "R3 same-cycle grant", 32'(cap_dr_valid), 0);
        grant(4'h7); cyc(); cyc();
        chk(cap_dr_valid && cap_dr_addr == 4'h7, "R3 later grant", 32'(cap_dr_addr), 7);

        // R7 and R8: three stores to address 6
        put(4'h6, 16'h1111, 2'b11); cyc();
        put(4'h6, 16'h2222, 2'b01); cyc();
        ld_hold = 1; ld_addr = 4'h6;
        put(4'h6, 16'h3333, 2'b10); cyc();
        chk(cap_ld_be == 2'b11 && cap_ld_data == 16'h1122, "R7 merge, same-cycle store hidden",
            32'(cap_ld_data), 32'h1122);
        cyc();
        chk(cap_ld_data == 16'h3322, "R7 youngest byte", 32'(cap_ld_data), 32'h3322);
        ld_hold = 0;
        grant(4'h6); cyc(); cyc();
        chk(cap_dr_data == 16'h1111, "R8 first", 32'(cap_dr_data), 32'h1111);
        cyc();
        chk(cap_dr_data == 16'h2222, "R8 second", 32'(cap_dr_data), 32'h2222);
        cyc();
        chk(cap_dr_data == 16'h3333, "R8 third", 32'(cap_dr_data), 32'h3333);
        chk(mem[6] == 16'h3322, "R8 image", 32'(mem[6]), 32'h3322);

        // R6: fill, then a fifth store is refused
        for (int i = 0; i < DEPTH; i++) begin put(4'(8 + i), 16'(i * 16'h0101), 2'b11); cyc(); end
        put(4'hC, 16'hCCCC, 2'b11); cyc();
        chk(!cap_st_ready, "R6 full", 32'(cap_st_ready), 0);
        grant(4'h8); cyc(); cyc();
        cyc();
        chk(cap_st_ready, "R6 slot freed", 32'(cap_st_ready), 1);

        // R9: full barrier waits for the buffer to empty
        fence_req = 1; cyc();
        chk(cap_fs && !cap_st_ready, "R9 stall", 32'(cap_fs), 1);
        grant(4'h9); cyc(); grant(4'hA); cyc(); grant(4'hB); cyc();
        for (int i = 0; i < 20 && !cap_empty; i++) cyc();
        chk(!cap_fs && cap_st_ready, "R9 released", 32'(cap_fs), 0);
        fence_req = 0;

        // random sweep against the model
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r;
            r = rnd();
            st_valid = (r[1:0] != 0); st_addr = {1'b0, r[4:2]}; st_data = r[31:16];
            st_be = (r[6:5] == 0) ? 2'b11 : r[6:5];
            sbar = (r[9:7] == 0);
            gnt_valid = (r[11:10] == 0); gnt_addr = {1'b0, r[14:12]};
            fence_req = (rnd() % 16 == 0);
            cyc();
        end
        fence_req = 0;
        for (int i = 0; i < 200 && !cap_empty; i++) begin grant(4'(i % 8)); cyc(); end
        cyc();
        chk(cap_empty, "R10 drained", 32'(cap_empty), 1);
        for (int a = 0; a < 16; a++)
            chk(mem[a] == img[a], "R8 final image", 32'(mem[a]), 32'(img[a]));

        summary();
        $finish;
    end
endmodule